// File: doc/BRIEF.md
# Write-only I2C command receiver

This block is the serial front end of a display driver. It watches an already synchronised SCL/SDA pair and answers to a 7-bit slave address. The upper six bits of that address are fixed and the lowest bit comes from a strap pin. It only ever receives. The single thing it drives onto the bus is the acknowledge, which it does by pulling SDA low.

Once it is addressed, the byte stream is parsed as control bytes followed by payload bytes. A control byte says whether the next payload bytes are commands or display RAM data. It also says whether another control byte follows after one payload byte, or whether every remaining byte of the transfer has the chosen type.

Several devices can share one slave address. They are told apart by a 3-bit hardware subaddress. A device-select command picks which subaddress is active. Only the selected device acknowledges bytes after the address, and only the selected device forwards commands and data, each as a one-cycle strobe with its byte.

Top module: `lcd_cmd_rx`

## Requirements
- R1: After reset, `sda_pull`, `cmd_valid` and `dat_valid` are all 0.
- R2: The address byte is acknowledged only when its bits 7..1 equal `0111 00` followed by `sa0`, and its bit 0 (read/write) is 0. On any other address byte the block gives no acknowledge and ignores the rest of the transfer.
- R3: The acknowledge pulls SDA low from the SCL falling edge after the 8th bit until the next SCL falling edge.
- R4: When the last control byte has bit 7 (continue) = 0 and bit 6 (select) = 1, every following byte of the transfer is forwarded as RAM data. Each byte gives one `dat_valid` pulse, in order of arrival.
- R5: When the last control byte has bit 6 = 0, the following bytes are forwarded as commands on `cmd_valid`/`cmd_byte`. `cmd_valid` and `dat_valid` are never high together.
- R6: A control byte with bit 7 = 1 covers exactly one payload byte, and the byte after that payload byte is parsed as a new control byte.
- R7: Subaddress 0 is selected when the address is acknowledged. A command byte of the form `01100sss` sets the selected subaddress to `sss` and is not forwarded. Bytes after the address are acknowledged and forwarded only while the selected subaddress equals `subaddr`.
- R8: A START or repeated START restarts address recognition, even in the middle of a byte. A STOP makes the block ignore the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL |
| sda_in | input | 1 | Synchronised SDA (bus level) |
| sa0 | input | 1 | Strap for the slave address LSB |
| subaddr | input | 3 | Hardware subaddress of this device |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| cmd_valid | output | 1 | One-cycle strobe for a command byte |
| cmd_byte | output | 8 | Command byte |
| dat_valid | output | 1 | One-cycle strobe for a RAM data byte |
| dat_byte | output | 8 | RAM data byte |

## Verification
Four kinds of address byte are driven: a matching write address, one with the wrong strap bit, and one with the read bit set. The wrong-strap and read-bit cases show that both the strap comparison and the direction bit are checked. A fourth case sends a matching address while the subaddress does not match, which shows that the address acknowledge does not depend on selection.

The payload tests cover several cases:
- An all-data stream and an all-command stream, which show that the select bit routes bytes correctly.
- A chained stream with the continue bit set, which shows that exactly one payload byte is taken per chained control byte.
- Selection changes both away from and back to this device, which show when acknowledges and strobes are gated.

Two restart cases close the set: a repeated START in the middle of a byte, and bytes sent after a STOP.

// File: rtl/lcd_cmd_rx.sv
module lcd_cmd_rx #(
  parameter logic [5:0] ADDR_HI = 6'b011100,
  parameter logic [4:0] DEVSEL_OP = 5'b01100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       sa0,
  input  logic [2:0] subaddr,
  output logic       sda_pull,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  output logic       dat_valid,
  output logic [7:0] dat_byte
);

  typedef enum logic [1:0] {P_IDLE, P_ADDR, P_CTRL, P_BODY} phase_t;

  phase_t     phase;
  logic       scl_d, sda_d;
  logic [6:0] shreg;
  logic [3:0] cnt;
  logic       in_ack, ack_req, cont_q, rs_q;
  logic [2:0] sel_q;

  wire scl_rise = scl_in & ~scl_d;
  wire scl_fall = ~scl_in & scl_d;
  wire bus_start = scl_in & scl_d & sda_d & ~sda_in;
  wire bus_stop  = scl_in & scl_d & ~sda_d & sda_in;
  wire [7:0] rx_byte = {shreg, sda_in};
  wire selected = (sel_q == subaddr);
  wire byte_done = scl_rise & ~in_ack & (cnt == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      shreg     <= '0;
      cnt       <= '0;
      in_ack    <= 1'b0;
      ack_req   <= 1'b0;
      cont_q    <= 1'b0;
      rs_q      <= 1'b0;
      sel_q     <= '0;
      sda_pull  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      dat_valid <= 1'b0;
      dat_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      dat_valid <= 1'b0;
      if (bus_start || bus_stop) begin
        phase    <= bus_start ? P_ADDR : P_IDLE;
        cnt      <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (phase != P_IDLE) begin
        if (scl_rise && !in_ack) begin
          shreg <= rx_byte[6:0];
          cnt   <= cnt + 4'd1;
        end
        if (byte_done) begin
          case (phase)
            P_ADDR: begin
              if (rx_byte == {ADDR_HI, sa0, 1'b0}) begin
                ack_req <= 1'b1;
                sel_q   <= '0;
                phase   <= P_CTRL;
              end else begin
                ack_req <= 1'b0;
                phase   <= P_IDLE;
              end
            end
            P_CTRL: begin
              cont_q  <= rx_byte[7];
              rs_q    <= rx_byte[6];
              ack_req <= selected;
              phase   <= P_BODY;
            end
            default: begin
              if (!rs_q && rx_byte[7:3] == DEVSEL_OP) begin
                sel_q   <= rx_byte[2:0];
                ack_req <= (rx_byte[2:0] == subaddr);
              end else begin
                ack_req <= selected;
                if (selected) begin
                  cmd_valid <= ~rs_q;
                  dat_valid <= rs_q;
                  if (rs_q) dat_byte <= rx_byte;
                  else cmd_byte <= rx_byte;
                end
              end
              if (cont_q) phase <= P_CTRL;
            end
          endcase
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            cnt      <= '0;
          end else if (cnt == 4'd8) begin
            in_ack   <= 1'b1;
            sda_pull <= ack_req;
          end
        end
      end
    end
  end

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull && scl_in && scl_d) |=> sda_pull);

  assert_ack_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && dat_valid));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |=> !dat_valid);

  assert_strobe_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || dat_valid) |-> $past(scl_rise));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(sel_q == subaddr));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_stop) |-> (!sda_pull && !cmd_valid && !dat_valid));

endmodule

// File: tb/tb_lcd_cmd_rx.sv
module tb_lcd_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, sa0 = 1'b1;
  logic [2:0] subaddr = 3'd0;
  logic sda_pull, cmd_valid, dat_valid;
  logic [7:0] cmd_byte, dat_byte;
  wire sda_bus = sda_drv & ~sda_pull;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] cmd_log[$];
  logic [7:0] dat_log[$];
  localparam logic [7:0] ADDR_W = 8'h72;

  always #2 clk = ~clk;

  lcd_cmd_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sa0(sa0),
    .subaddr(subaddr), .sda_pull(sda_pull), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .dat_valid(dat_valid), .dat_byte(dat_byte)
  );

  always @(negedge clk) begin
    if (cmd_valid) cmd_log.push_back(cmd_byte);
    if (dat_valid) dat_log.push_back(dat_byte);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, got=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    sda_drv = 1'b1; w(4); scl = 1'b1; w(6); sda_drv = 1'b0; w(6); scl = 1'b0; w(4);
  endtask

  task automatic stop_c;
    sda_drv = 1'b0; w(4); scl = 1'b1; w(6); sda_drv = 1'b1; w(6);
  endtask

  task automatic bit_c(logic b);
    sda_drv = b; w(4); scl = 1'b1; w(8); scl = 1'b0; w(4);
  endtask

  task automatic byte_c(logic [7:0] b, output logic acked);
    int held;
    for (int i = 7; i >= 0; i--) bit_c(b[i]);
    sda_drv = 1'b1; w(4);
    held = sda_pull;
    scl = 1'b1; w(4);
    acked = sda_pull;
    w(4); scl = 1'b0; w(1);
    if (held != acked) acked = 1'b0;
    w(3);
  endtask

  task automatic send_chk(logic [7:0] b, logic exp_ack, string req);
    logic a;
    byte_c(b, a);
    chk(req, a, exp_ack);
  endtask

  task automatic logs_chk(string req, logic [7:0] ec[$], logic [7:0] ed[$]);
    chk({req, " cmd count"}, cmd_log.size(), ec.size());
    foreach (ec[i]) if (i < cmd_log.size()) chk({req, " cmd"}, cmd_log[i], ec[i]);
    chk({req, " dat count"}, dat_log.size(), ed.size());
    foreach (ed[i]) if (i < dat_log.size()) chk({req, " dat"}, dat_log[i], ed[i]);
    cmd_log.delete(); dat_log.delete();
  endtask

  task automatic t_reset;
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 dat_valid", dat_valid, 0);
  endtask

  task automatic t_bad_addr;
    start_c; send_chk(8'h70, 1'b0, "R2 wrong sa0"); send_chk(8'h40, 1'b0, "R2 ignored after"); stop_c;
    start_c; send_chk(8'h73, 1'b0, "R2 read bit"); send_chk(8'h40, 1'b0, "R2 ignored after read"); stop_c;
    logs_chk("R2", '{}, '{});
  endtask

  task automatic t_data;
    start_c; send_chk(ADDR_W, 1'b1, "R3 addr ack");
    send_chk(8'h40, 1'b1, "R4 ctrl");
    send_chk(8'hA5, 1'b1, "R4 d0"); send_chk(8'h3C, 1'b1, "R4 d1"); send_chk(8'h80, 1'b1, "R4 d2");
    stop_c;
    logs_chk("R4", '{}, '{8'hA5, 8'h3C, 8'h80});
  endtask

  task automatic t_cmd;
    start_c; send_chk(ADDR_W, 1'b1, "R5 addr");
    send_chk(8'h00, 1'b1, "R5 ctrl");
    send_chk(8'hC8, 1'b1, "R5 c0"); send_chk(8'h41, 1'b1, "R5 c1");
    stop_c;
    logs_chk("R5", '{8'hC8, 8'h41}, '{});
  endtask

  task automatic t_chain;
    start_c; send_chk(ADDR_W, 1'b1, "R6 addr");
    send_chk(8'h80, 1'b1, "R6 ctrl cmd");
    send_chk(8'hE1, 1'b1, "R6 c0");
    send_chk(8'h40, 1'b1, "R6 ctrl dat");
    send_chk(8'h80, 1'b1, "R6 d0"); send_chk(8'h40, 1'b1, "R6 d1");
    stop_c;
    logs_chk("R6", '{8'hE1}, '{8'h80, 8'h40});
  endtask

  task automatic t_select;
    subaddr = 3'd3; w(4);
    start_c; send_chk(ADDR_W, 1'b1, "R7 addr ack unselected");
    send_chk(8'h00, 1'b0, "R7 ctrl nack unselected");
    send_chk(8'h63, 1'b1, "R7 select own");
    send_chk(8'h21, 1'b1, "R7 cmd selected");
    send_chk(8'h61, 1'b0, "R7 select other");
    send_chk(8'h22, 1'b0, "R7 cmd unselected");
    stop_c;
    logs_chk("R7", '{8'h21}, '{});
    subaddr = 3'd0; w(4);
  endtask

  task automatic t_restart;
    start_c; send_chk(ADDR_W, 1'b1, "R8 addr");
    send_chk(8'h40, 1'b1, "R8 ctrl");
    bit_c(1'b1); bit_c(1'b0); bit_c(1'b1);
    start_c; send_chk(ADDR_W, 1'b1, "R8 re-addr");
    send_chk(8'h40, 1'b1, "R8 ctrl2"); send_chk(8'h5A, 1'b1, "R8 d0");
    stop_c;
    send_chk(8'h40, 1'b0, "R8 after stop a"); send_chk(8'h11, 1'b0, "R8 after stop b");
    logs_chk("R8", '{}, '{8'h5A});
  endtask

  initial begin
    w(5); t_reset; rst_n = 1'b1; w(5); t_reset;
    t_bad_addr;
    t_data;
    t_cmd;
    t_chain;
    t_select;
    t_restart;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule